// File: doc/BRIEF.md
# Page-Splitting Flash Program Scheduler

This block takes one request to program, erase or read a serial NOR flash and turns it into a series of single operations for a downstream flash sequencer. A program request may start at any byte address and have any length. The block cuts it into chunks that never cross a 256-byte page. Every chunk gets its own write-enable and page-program, and then a busy poll that repeats a one-byte status read until the write-in-progress flag clears.

Erase requests must start on a sector boundary and cover at least one sector. They are carried out one sector at a time, with the same write-enable and busy-poll pattern. A read request becomes a single read operation. When a program or erase request completes without error, a one-cycle pulse tells the read cache to drop its contents.

Requests arrive on a valid/ready interface. Each operation goes to the sequencer on a valid/ready handshake and finishes with a done strobe, which carries the status byte for status reads. The end of a request is a one-cycle done pulse with an error flag. A programmable limit bounds each busy poll.

Top module: `flash_pgm_sched`

## Requirements
- R1: `req_ready` is high only while the block is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. `done` is a single-cycle pulse, and `req_ready` is high again on the cycle after it.
- R2: In program mode (`req_mode` = 0), the first chunk runs from the start address up to the next 256-byte page boundary, or covers the whole request if that is shorter. No page-program operation crosses a page boundary or has zero length.
- R3: After the first chunk come as many full 256-byte chunks as fit, then one final chunk with the bytes that remain, if any.
- R4: Each program chunk issues these operations in order:
  - a write-enable (`seq_op` = 0) at the chunk address with length 0;
  - a page-program (`seq_op` = 1) with the chunk address and length;
  - status reads (`seq_op` = 3, address 0, length 1), repeated until bit 0 of `seq_status` is clear. The other status bits are ignored.
- R5: An erase request (`req_mode` = 1) is rejected with `error` set, with no sequencer operation and no invalidate, in either case:
  - its address is not a multiple of the sector size;
  - its length is below one sector.
- R6: An accepted erase covers ceil(length / sector size) sectors. Each sector issues a write-enable, then an erase (`seq_op` = 2, sector address, length 0), then the busy poll of R4.
- R7: `inval` pulses together with `done` only when a program or erase request completes without error.
- R8: A read request (`req_mode` = 2) with zero length is rejected with `error`. Any other read issues exactly one read operation (`seq_op` = 4) with the request address and length, with no poll and no invalidate.
- R9: A program request with zero length is rejected with `error`, and so is a request with `req_mode` = 3. Neither issues any sequencer operation.
- R10: A status result with bit 0 set ends the request with `error` if at least `tmo_limit` cycles have passed in the poll loop since that chunk's main operation was accepted. No further operation is issued after that.
- R11: While `seq_valid` is high and `seq_ready` is low, `seq_valid`, `seq_op`, `seq_addr` and `seq_len` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Length in bytes |
| req_mode | input | 2 | 0 program, 1 erase, 2 read |
| tmo_limit | input | TMO_W | Busy-poll cycle limit |
| seq_valid | output | 1 | Operation offered to sequencer |
| seq_ready | input | 1 | Sequencer accepts operation |
| seq_op | output | 3 | 0 write-enable, 1 program, 2 erase, 3 status read, 4 read |
| seq_addr | output | AW | Operation address |
| seq_len | output | LW | Operation length in bytes |
| seq_done | input | 1 | Sequencer finished the accepted operation |
| seq_status | input | 8 | Status byte, valid with `seq_done` after a status read |
| done | output | 1 | Request complete pulse |
| error | output | 1 | Request failed, valid with `done` |
| inval | output | 1 | Read cache invalidate pulse |

## Verification
A rejected request raises `done` on the cycle after the accepting edge. An accepted request keeps each operation on the sequencer port from the cycle after the previous done strobe until the handshake edge, and raises `done` on the cycle after the last status result. Because these delays depend on how fast the sequencer responds, the bench drives all inputs on the falling edge and samples `done`, `error` and `inval` on the same falling edge where `done` first shows high, within a cycle bound. The bench records every sequencer handshake on the falling edge before it happens and compares that log, entry by entry, with an operation list computed from the request.

// File: rtl/fps_pkg.sv
`timescale 1ns/1ps
package fps_pkg;

   typedef enum logic [1:0] {
      MODE_PROG  = 2'd0,
      MODE_ERASE = 2'd1,
      MODE_READ  = 2'd2,
      MODE_RSVD  = 2'd3
   } fps_mode_e;

   typedef enum logic [2:0] {
      OP_WREN  = 3'd0,
      OP_PROG  = 3'd1,
      OP_ERASE = 3'd2,
      OP_RDSR  = 3'd3,
      OP_READ  = 3'd4
   } fps_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WREN,
      ST_WREN_W,
      ST_MAIN,
      ST_MAIN_W,
      ST_POLL,
      ST_POLL_W,
      ST_DONE
   } fps_state_e;

endpackage

// File: rtl/fps_req_check.sv
`timescale 1ns/1ps
// Decides whether a request must be refused before any flash operation.
module fps_req_check
   import fps_pkg::*;
#(
   parameter int AW           = 32,
   parameter int LW           = 24,
   parameter int SECTOR_BYTES = 65536
) (
   input  logic [AW-1:0] addr,
   input  logic [LW-1:0] len,
   input  logic [1:0]    mode,
   output logic          reject
);
   localparam int SECTOR_LG = $clog2(SECTOR_BYTES);

   logic addr_hi_unused;
   assign addr_hi_unused = ^addr[AW-1:SECTOR_LG];

   always_comb begin
      case (fps_mode_e'(mode))
         MODE_PROG,
         MODE_READ:  reject = (len == '0);
         MODE_ERASE: reject = (addr[SECTOR_LG-1:0] != '0) ||
                              (len < LW'(SECTOR_BYTES));
         default:    reject = 1'b1;
      endcase
   end
endmodule

// File: rtl/fps_chunk_calc.sv
`timescale 1ns/1ps
// Size of the next operation: bounded by page room (program) or one sector (erase).
module fps_chunk_calc #(
   parameter int LW           = 24,
   parameter int PAGE_BYTES   = 256,
   parameter int SECTOR_BYTES = 65536
) (
   input  logic [$clog2(PAGE_BYTES)-1:0] addr_lo,
   input  logic [LW-1:0]                 remain,
   input  logic                          erase,
   output logic [LW-1:0]                 chunk
);
   localparam int PAGE_LG = $clog2(PAGE_BYTES);

   logic [PAGE_LG:0] room;
   logic [LW-1:0]    room_w;
   logic [LW-1:0]    prog_chunk;
   logic [LW-1:0]    erase_chunk;

   assign room        = (PAGE_LG+1)'(PAGE_BYTES) - {1'b0, addr_lo};
   assign room_w      = LW'(room);
   assign prog_chunk  = (remain < room_w) ? remain : room_w;
   assign erase_chunk = (remain < LW'(SECTOR_BYTES)) ? remain : LW'(SECTOR_BYTES);
   assign chunk       = erase ? erase_chunk : prog_chunk;
endmodule

// File: rtl/fps_poll_timer.sv
`timescale 1ns/1ps
// Saturating cycle counter for one busy-poll loop.
module fps_poll_timer #(
   parameter int TW          = 16,
   parameter bit USE_TIMEOUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          expired
);
   generate
      if (USE_TIMEOUT) begin : g_tmo
         logic [TW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt_q <= '0;
            else if (clr)                 cnt_q <= '0;
            else if (run && cnt_q != '1)  cnt_q <= cnt_q + TW'(1);
         end
         assign expired = (cnt_q >= limit);
      end else begin : g_none
         logic tmo_unused;
         assign tmo_unused = clk ^ rst_n ^ clr ^ run ^ (^limit);
         assign expired    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/flash_pgm_sched.sv
`timescale 1ns/1ps
module flash_pgm_sched
   import fps_pkg::*;
#(
   parameter int AW           = 32,
   parameter int LW           = 24,
   parameter int PAGE_BYTES   = 256,
   parameter int SECTOR_BYTES = 65536,
   parameter int TMO_W        = 16,
   parameter bit USE_TIMEOUT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [AW-1:0]    req_addr,
   input  logic [LW-1:0]    req_len,
   input  logic [1:0]       req_mode,
   input  logic [TMO_W-1:0] tmo_limit,
   output logic             seq_valid,
   input  logic             seq_ready,
   output logic [2:0]       seq_op,
   output logic [AW-1:0]    seq_addr,
   output logic [LW-1:0]    seq_len,
   input  logic             seq_done,
   input  logic [7:0]       seq_status,
   output logic             done,
   output logic             error,
   output logic             inval
);
   localparam int PAGE_LG   = $clog2(PAGE_BYTES);
   localparam int SECTOR_LG = $clog2(SECTOR_BYTES);

   initial begin
      if ((1 << PAGE_LG) != PAGE_BYTES)     $fatal(1, "page size must be a power of two");
      if ((1 << SECTOR_LG) != SECTOR_BYTES) $fatal(1, "sector size must be a power of two");
      if (SECTOR_BYTES < PAGE_BYTES)        $fatal(1, "sector smaller than page");
      if (LW <= SECTOR_LG)                  $fatal(1, "length width cannot hold a sector");
      if (AW <= SECTOR_LG)                  $fatal(1, "address width too small");
      if (TMO_W < 1)                        $fatal(1, "timeout width must be positive");
   end

   fps_state_e      state_q;
   fps_mode_e       mode_q;
   logic [AW-1:0]   addr_q;
   logic [LW-1:0]   remain_q;
   logic            err_q;

   logic            reject;
   logic [LW-1:0]   chunk;
   logic            expired;
   logic            status_hi_unused;

   assign status_hi_unused = ^seq_status[7:1];

   fps_req_check #(
      .AW(AW), .LW(LW), .SECTOR_BYTES(SECTOR_BYTES)
   ) u_check (
      .addr(req_addr), .len(req_len), .mode(req_mode), .reject(reject)
   );

   fps_chunk_calc #(
      .LW(LW), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
   ) u_chunk (
      .addr_lo(addr_q[PAGE_LG-1:0]), .remain(remain_q),
      .erase(mode_q == MODE_ERASE), .chunk(chunk)
   );

   fps_poll_timer #(
      .TW(TMO_W), .USE_TIMEOUT(USE_TIMEOUT)
   ) u_timer (
      .clk(clk), .rst_n(rst_n),
      .clr(state_q == ST_MAIN),
      .run((state_q == ST_POLL) || (state_q == ST_POLL_W)),
      .limit(tmo_limit), .expired(expired)
   );

   // Operation offered to the sequencer
   always_comb begin
      seq_valid = 1'b0;
      seq_op    = OP_WREN;
      seq_addr  = '0;
      seq_len   = '0;
      case (state_q)
         ST_WREN: begin
            seq_valid = 1'b1;
            seq_op    = OP_WREN;
            seq_addr  = addr_q;
         end
         ST_MAIN: begin
            seq_valid = 1'b1;
            seq_addr  = addr_q;
            case (mode_q)
               MODE_ERASE: seq_op = OP_ERASE;
               MODE_READ: begin
                  seq_op  = OP_READ;
                  seq_len = remain_q;
               end
               default: begin
                  seq_op  = OP_PROG;
                  seq_len = chunk;
               end
            endcase
         end
         ST_POLL: begin
            seq_valid = 1'b1;
            seq_op    = OP_RDSR;
            seq_len   = LW'(1);
         end
         default: ;
      endcase
   end

   // Request sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         mode_q   <= MODE_PROG;
         addr_q   <= '0;
         remain_q <= '0;
         err_q    <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               addr_q   <= req_addr;
               remain_q <= req_len;
               mode_q   <= fps_mode_e'(req_mode);
               err_q    <= reject;
               if (reject)                                  state_q <= ST_DONE;
               else if (fps_mode_e'(req_mode) == MODE_READ) state_q <= ST_MAIN;
               else                                         state_q <= ST_WREN;
            end
            ST_WREN:   if (seq_ready) state_q <= ST_WREN_W;
            ST_WREN_W: if (seq_done)  state_q <= ST_MAIN;
            ST_MAIN: if (seq_ready) begin
               if (mode_q == MODE_READ) begin
                  remain_q <= '0;
               end else begin
                  addr_q   <= addr_q + AW'(chunk);
                  remain_q <= remain_q - chunk;
               end
               state_q <= ST_MAIN_W;
            end
            ST_MAIN_W: if (seq_done)
               state_q <= (mode_q == MODE_READ) ? ST_DONE : ST_POLL;
            ST_POLL:   if (seq_ready) state_q <= ST_POLL_W;
            ST_POLL_W: if (seq_done) begin
               if (!seq_status[0]) begin
                  state_q <= (remain_q == '0) ? ST_DONE : ST_WREN;
               end else if (expired) begin
                  err_q   <= 1'b1;
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_POLL;
               end
            end
            ST_DONE:   state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign error     = done & err_q;
   assign inval     = done & ~err_q & (mode_q != MODE_READ);
endmodule

// File: rtl/fps_sva.sv
`timescale 1ns/1ps
module fps_sva #(
   parameter int AW           = 32,
   parameter int LW           = 24,
   parameter int PAGE_BYTES   = 256,
   parameter int SECTOR_BYTES = 65536
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          seq_valid,
   input logic          seq_ready,
   input logic [2:0]    seq_op,
   input logic [AW-1:0] seq_addr,
   input logic [LW-1:0] seq_len,
   input logic          done,
   input logic          error,
   input logic          inval
);
   localparam int PAGE_LG   = $clog2(PAGE_BYTES);
   localparam int SECTOR_LG = $clog2(SECTOR_BYTES);

   logic [LW:0] span;
   logic        addr_hi_unused;
   assign span           = {1'b0, seq_len} + (LW+1)'(seq_addr[PAGE_LG-1:0]);
   assign addr_hi_unused = ^seq_addr[AW-1:SECTOR_LG];

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_valid && !seq_ready) |=> (seq_valid && $stable(seq_op) &&
                                     $stable(seq_addr) && $stable(seq_len)));

   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      seq_valid |-> !req_ready);

   assert_inval_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
      inval |-> (done && !error));

   assert_page_fit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_valid && seq_op == 3'd1) |-> ((span <= (LW+1)'(PAGE_BYTES)) && (seq_len != '0)));

   assert_sector_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_valid && seq_op == 3'd2) |-> (seq_addr[SECTOR_LG-1:0] == '0));
endmodule

bind flash_pgm_sched fps_sva #(
   .AW(AW), .LW(LW), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
) u_sva (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .seq_valid(seq_valid),
   .seq_ready(seq_ready), .seq_op(seq_op), .seq_addr(seq_addr), .seq_len(seq_len),
   .done(done), .error(error), .inval(inval)
);

// File: tb/flash_pgm_sched_tb.sv
`timescale 1ns/1ps
module flash_pgm_sched_tb_top;
   localparam int AW   = 32;
   localparam int LW   = 24;
   localparam int PAGE = 256;
   localparam int SECT = 65536;
   localparam int LOGN = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic [1:0]    req_mode = '0;
   logic [15:0]   tmo_limit = 16'd1000;
   logic          seq_valid;
   logic          seq_ready = 1'b1;
   logic [2:0]    seq_op;
   logic [AW-1:0] seq_addr;
   logic [LW-1:0] seq_len;
   logic          seq_done = 1'b0;
   logic [7:0]    seq_status = 8'h00;
   logic          done, error, inval;

   flash_pgm_sched #(.AW(AW), .LW(LW), .PAGE_BYTES(PAGE), .SECTOR_BYTES(SECT)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode), .tmo_limit(tmo_limit),
      .seq_valid(seq_valid), .seq_ready(seq_ready), .seq_op(seq_op),
      .seq_addr(seq_addr), .seq_len(seq_len), .seq_done(seq_done),
      .seq_status(seq_status), .done(done), .error(error), .inval(inval)
   );

   initial forever #10 clk = ~clk;

   int chks = 0;
   int errs = 0;

   int          log_op   [LOGN];
   logic [31:0] log_addr [LOGN];
   int          log_len  [LOGN];
   int          log_n = 0;
   int          exp_op   [LOGN];
   logic [31:0] exp_addr [LOGN];
   int          exp_len  [LOGN];
   int          exp_n = 0;

   int busy_cfg  = 0;
   int busy_left = 0;
   bit stall = 0;

   // Sequencer model: logs each handshake, answers one cycle later.
   initial begin
      bit pend = 0;
      bit stalled = 0;
      int pend_op = 0;
      forever begin
         @(negedge clk);
         seq_done = 1'b0;
         if (pend) begin
            seq_done = 1'b1;
            if (pend_op == 3) begin
               if (busy_left > 0) begin
                  seq_status = 8'h03;
                  busy_left--;
               end else begin
                  seq_status = 8'h02;
               end
            end else begin
               seq_status = 8'h00;
            end
            pend = 0;
         end else if (seq_valid) begin
            if (stall && !stalled) begin
               seq_ready = 1'b0;
               stalled = 1;
            end else begin
               seq_ready = 1'b1;
               stalled = 0;
               if (log_n < LOGN) begin
                  log_op[log_n]   = int'(seq_op);
                  log_addr[log_n] = seq_addr;
                  log_len[log_n]  = int'(seq_len);
               end
               log_n++;
               pend = 1;
               pend_op = int'(seq_op);
               if (seq_op != 3'd3) busy_left = busy_cfg;
            end
         end
      end
   end

   task automatic chk(input bit cond, input string req, input string what,
                      input longint act, input longint exp);
      chks++;
      if (!cond) begin
         errs++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic exp_push(input int op, input logic [31:0] a, input int l);
      if (exp_n < LOGN) begin
         exp_op[exp_n] = op; exp_addr[exp_n] = a; exp_len[exp_n] = l;
      end
      exp_n++;
   endtask

   task automatic build_prog(input logic [31:0] a, input int len, input int busy);
      logic [31:0] p = a;
      int r = len;
      exp_n = 0;
      while (r > 0) begin
         int room = PAGE - int'(p % PAGE);
         int c = (r < room) ? r : room;
         exp_push(0, p, 0);
         exp_push(1, p, c);
         for (int k = 0; k <= busy; k++) exp_push(3, 0, 1);
         p += c;
         r -= c;
      end
   endtask

   task automatic build_erase(input logic [31:0] a, input int len, input int busy);
      int ns = (len + SECT - 1) / SECT;
      exp_n = 0;
      for (int i = 0; i < ns; i++) begin
         exp_push(0, a + i*SECT, 0);
         exp_push(2, a + i*SECT, 0);
         for (int k = 0; k <= busy; k++) exp_push(3, 0, 1);
      end
   endtask

   task automatic cmp_log(input string req);
      int bad = -1;
      chk(log_n == exp_n, req, "operation count", log_n, exp_n);
      for (int i = 0; i < exp_n && i < log_n && i < LOGN; i++)
         if (bad < 0 && (log_op[i] != exp_op[i] || log_addr[i] != exp_addr[i] ||
                         log_len[i] != exp_len[i])) bad = i;
      if (bad >= 0)
         chk(0, req, $sformatf("op %0d (op/addr/len %0d/%0h/%0h)", bad,
             exp_op[bad], exp_addr[bad], exp_len[bad]),
             {log_op[bad][7:0], log_addr[bad], log_len[bad][23:0]},
             {exp_op[bad][7:0], exp_addr[bad], exp_len[bad][23:0]});
      else
         chk(1, req, "operation sequence", 0, 0);
   endtask

   // Issues a request and waits for done, sampling on falling edges.
   task automatic run_req(input logic [31:0] a, input int l, input int m,
                          output bit e, output bit iv, output bit rdy_bad,
                          output bit post_done, output bit post_rdy);
      int n = 0;
      @(negedge clk);
      log_n = 0;
      req_addr = a; req_len = LW'(l); req_mode = 2'(m); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rdy_bad = 0;
      while (!done && n < 20000) begin
         if (req_ready) rdy_bad = 1;
         @(negedge clk);
         n++;
      end
      chk(n < 20000, "R1", "watchdog: done never seen", n, 0);
      e = error;
      iv = inval;
      @(negedge clk);
      post_done = done;
      post_rdy = req_ready;
   endtask

   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
      chk(seq_valid == 1'b0, "R1", "reset seq_valid", seq_valid, 0);
      chk(done == 1'b0, "R1", "reset done", done, 0);
      chk(inval == 1'b0, "R7", "reset inval", inval, 0);
   endtask

   task automatic t_prog(input string req, input logic [31:0] a, input int l,
                         input int busy, input bit stl);
      bit e, iv, rb, pd, pr;
      busy_cfg = busy; stall = stl;
      build_prog(a, l, busy);
      run_req(a, l, 0, e, iv, rb, pd, pr);
      cmp_log(req);
      chk(e == 0, req, "program error flag", e, 0);
      chk(iv == 1, "R7", "invalidate with program done", iv, 1);
      chk(rb == 0, "R1", "req_ready low while busy", rb, 0);
      chk(pd == 0 && pr == 1, "R1", "done single cycle, ready after", {pd, pr}, 1);
      stall = 0;
   endtask

   task automatic t_erase_ok();
      bit e, iv, rb, pd, pr;
      busy_cfg = 2;
      build_erase(32'h0002_0000, 32'h18000, 2);
      run_req(32'h0002_0000, 32'h18000, 1, e, iv, rb, pd, pr);
      cmp_log("R6");
      chk(e == 0 && iv == 1, "R7", "erase error/inval", {e, iv}, 1);
      build_erase(32'h0005_0000, SECT, 0);
      busy_cfg = 0;
      run_req(32'h0005_0000, SECT, 1, e, iv, rb, pd, pr);
      cmp_log("R6");
   endtask

   task automatic t_reject(input string req, input logic [31:0] a, input int l, input int m);
      bit e, iv, rb, pd, pr;
      run_req(a, l, m, e, iv, rb, pd, pr);
      chk(e == 1, req, "error flag on rejected request", e, 1);
      chk(iv == 0, req, "no invalidate on rejection", iv, 0);
      chk(log_n == 0, req, "no sequencer operation", log_n, 0);
   endtask

   task automatic t_read();
      bit e, iv, rb, pd, pr;
      t_reject("R8", 32'h100, 0, 2);
      exp_n = 0;
      exp_push(4, 32'h55, 16);
      run_req(32'h55, 16, 2, e, iv, rb, pd, pr);
      cmp_log("R8");
      chk(e == 0 && iv == 0, "R8", "read error/inval", {e, iv}, 0);
   endtask

   task automatic t_timeout();
      bit e, iv, rb, pd, pr;
      int n_after;
      busy_cfg = 1000;
      tmo_limit = 16'd20;
      run_req(32'h800, 8, 0, e, iv, rb, pd, pr);
      chk(e == 1, "R10", "timeout error flag", e, 1);
      chk(iv == 0, "R10", "no invalidate after timeout", iv, 0);
      chk(log_n >= 4 && log_op[0] == 0 && log_op[1] == 1 && log_op[log_n-1] == 3,
          "R10", "write-enable, program then repeated polls", log_n, 4);
      n_after = log_n;
      repeat (5) @(negedge clk);
      chk(log_n == n_after, "R10", "no operation after timeout", log_n, n_after);
      tmo_limit = 16'd1000;
      busy_cfg = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog("R2", 32'h0000_1000, 256, 0, 0);
      t_prog("R2", 32'h0000_0110, 32'h15, 0, 0);
      t_prog("R3", 32'h0000_01EF, 32'h229, 1, 0);
      t_prog("R3", 32'h0000_0300, 32'h281, 0, 0);
      t_prog("R4", 32'h0000_0040, 32'h40, 3, 0);
      t_prog("R11", 32'h0000_0A10, 32'h120, 1, 1);
      t_erase_ok();
      t_reject("R5", 32'h0002_1000, SECT, 1);
      t_reject("R5", 32'h0003_0000, SECT - 1, 1);
      t_read();
      t_reject("R9", 32'h0000_0000, 0, 0);
      t_reject("R9", 32'h0000_0000, 16, 3);
      t_timeout();
      $display("Simulation finished: %0d checks, %0d errors", chks, errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chks++;
      errs++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", chks, errs);
      $finish;
   end
endmodule